// File: doc/BRIEF.md
# Ones-Proportion Bin Classifier and Labeler

This block grades a bank of noisy single-bit sources, one source at a time. For the source it is currently selecting, it accepts a fixed window of serial samples, counts how many were one, and places that count into one of K bins. The two end bins hold only exact cases: a window with no ones at all, and a window with nothing but ones. The bins between them split the open interval of proportions into equal slices. The bin number is then turned into a fixed-width code. A middle stretch of binary values is left unused, so the top bin always gets the all-ones code and the bottom bin always gets the all-zeros code.

Each code is offered on a valid/ready output stream and is also written into a wide response vector, with each source in its own slice. One start pulse sweeps every source in ascending order. When the last code has been accepted, a done flag rises. Samples arrive on a valid/ready stream. The block raises sample-ready only while it is measuring. While a code waits for its consumer, no sample is taken and the sweep does not move on. This lets a slow consumer stall the whole sweep without losing data. The bank size, window length and bin count are parameters.

Top module: `opbc_top`

## Requirements
- R1: After reset, `src_sel_o` is 0, and `smp_ready_o`, `code_valid_o`, `done_o` and all bits of `response_o` are 0.
- R2: In the idle state, a cycle with `start_i` high starts a sweep at source 0. From the next cycle `smp_ready_o` is high, `src_sel_o` is 0, and `done_o` is low.
- R3: For each source, exactly WIN_LEN samples are accepted, each one on a cycle where `smp_valid_i` and `smp_ready_o` are both high. The ones among them are counted. After the last sample, `smp_ready_o` drops and one code is presented.
- R4: A window with zero ones falls in bin 0, and its code is all zeros.
- R5: A window in which every sample is one falls in bin K-1, and its code is all ones.
- R6: For any other count c, the bin is the smallest k in 1..K-2 with c·(K-2) ≤ k·WIN_LEN. With K=6 and WIN_LEN=8: c=1..2 give bin 1, c=3..4 give bin 2, c=5..6 give bin 3, and c=7 gives bin 4.
- R7: With b = ceil(log2 K), a bin k below floor(K/2) has code k, and any other bin has code 2^b − K + k. For K=6 the codes for bins 0..5 are 000, 001, 010, 101, 110, 111.
- R8: While `code_valid_o` is high and `code_ready_i` is low, `code_data_o` and `code_src_o` hold their values and `smp_ready_o` stays low. A code is consumed on a cycle where valid and ready are both high.
- R9: Codes come out in ascending source order, and `code_src_o` gives the index of the source each code belongs to.
- R10: When a code is consumed for source i, it is written to `response_o[i*b +: b]`. Source N-1 therefore occupies the most significant slice.
- R11: `done_o` rises in the cycle after the code for source N-1 is consumed. It stays high, with no sample or code activity, until the next start.
- R12: A start pulse while a sweep is in progress has no effect. The current source, its running count and the sweep order are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a sweep of all sources (acted on only when idle) |
| src_sel_o | output | SRC_W | Index of the source being measured |
| smp_valid_i | input | 1 | Sample stream valid |
| smp_bit_i | input | 1 | Sample value |
| smp_ready_o | output | 1 | Sample stream ready (high only while measuring) |
| code_valid_o | output | 1 | Code stream valid |
| code_ready_i | input | 1 | Code stream ready from the consumer |
| code_data_o | output | CODE_W | Bin code for the current source |
| code_src_o | output | SRC_W | Source index that the code belongs to |
| done_o | output | 1 | Every source has been graded |
| response_o | output | NUM_SRC*CODE_W | Concatenated codes, source N-1 at the MSB end |

## Verification
The hardest case to reach is the boundary between bins. Counts that land exactly on k·WIN_LEN/(K-2) must stay in the lower bin, and counts one above must move up. With the default window, such counts are rare. The bench therefore uses a window of 8 and K=6, where every boundary count is a whole number. Three sweeps give the sources counts from 0 through 8, so every bin and both sides of each boundary are visited. The ones are scattered through the window by a stride permutation. A stalling consumer holds codes pending across several cycles, and one start pulse arrives in the middle of a window.

// File: rtl/opbc_pkg.sv
package opbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEAS = 2'd1,
    ST_EMIT = 2'd2
  } opbc_state_e;

  // Map a bin number to its code: lower half keeps its value, upper half
  // is shifted up so that the last bin lands on all ones.
  function automatic int label_of(input int bin, input int nbins, input int cw);
    if (bin < nbins / 2) return bin;
    return (1 << cw) - nbins + bin;
  endfunction
endpackage

// File: rtl/opbc_ones_counter.sv
module opbc_ones_counter #(
  parameter int WIN_LEN = 1024,
  localparam int IDX_W = $clog2(WIN_LEN),
  localparam int CNT_W = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             bit_i,
  output logic [CNT_W-1:0] ones_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] ones_q;

  assign last_o = take_i && (idx_q == IDX_W'(WIN_LEN - 1));
  assign ones_o = ones_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      idx_q  <= '0;
      ones_q <= '0;
    end else if (take_i) begin
      idx_q  <= last_o ? '0 : idx_q + IDX_W'(1);
      ones_q <= ones_q + CNT_W'(bit_i);
    end
  end

  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= CNT_W'(WIN_LEN));
endmodule

// File: rtl/opbc_bin_classifier.sv
module opbc_bin_classifier #(
  parameter int WIN_LEN  = 1024,
  parameter int NUM_BINS = 6,
  localparam int CNT_W  = $clog2(WIN_LEN + 1),
  localparam int BIN_W  = $clog2(NUM_BINS),
  localparam int PROD_W = CNT_W + 5
) (
  input  logic [CNT_W-1:0] ones_i,
  output logic [BIN_W-1:0] bin_o
);
  logic [PROD_W-1:0] scaled;

  assign scaled = PROD_W'(ones_i) * PROD_W'(NUM_BINS - 2);

  always_comb begin
    bin_o = BIN_W'(NUM_BINS - 1);
    if (ones_i == '0) begin
      bin_o = '0;
    end else if (ones_i != CNT_W'(WIN_LEN)) begin
      for (int k = NUM_BINS - 2; k >= 1; k--) begin
        if (scaled <= PROD_W'(k) * PROD_W'(WIN_LEN)) bin_o = BIN_W'(k);
      end
    end
  end
endmodule

// File: rtl/opbc_labeler.sv
module opbc_labeler #(
  parameter int NUM_BINS = 6,
  localparam int CODE_W = $clog2(NUM_BINS)
) (
  input  logic [CODE_W-1:0] bin_i,
  output logic [CODE_W-1:0] code_o
);
  int lab;

  always_comb begin
    lab    = opbc_pkg::label_of(int'(bin_i), NUM_BINS, CODE_W);
    code_o = lab[CODE_W-1:0];
  end
endmodule

// File: rtl/opbc_top.sv
module opbc_top #(
  parameter int NUM_SRC  = 256,
  parameter int WIN_LEN  = 1024,
  parameter int NUM_BINS = 6,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int CODE_W = $clog2(NUM_BINS),
  localparam int CNT_W  = $clog2(WIN_LEN + 1),
  localparam int RESP_W = NUM_SRC * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [SRC_W-1:0]  src_sel_o,
  input  logic              smp_valid_i,
  input  logic              smp_bit_i,
  output logic              smp_ready_o,
  output logic              code_valid_o,
  input  logic              code_ready_i,
  output logic [CODE_W-1:0] code_data_o,
  output logic [SRC_W-1:0]  code_src_o,
  output logic              done_o,
  output logic [RESP_W-1:0] response_o
);
  import opbc_pkg::*;

  opbc_state_e       state_q;
  logic [SRC_W-1:0]  src_q;
  logic              done_q;
  logic [RESP_W-1:0] resp_q;
  logic              take, last, clear, consume;
  logic [CNT_W-1:0]  ones;
  logic [CODE_W-1:0] bin, code;

  assign smp_ready_o  = (state_q == ST_MEAS);
  assign code_valid_o = (state_q == ST_EMIT);
  assign take    = smp_ready_o && smp_valid_i;
  assign consume = code_valid_o && code_ready_i;
  assign clear   = ((state_q == ST_IDLE) && start_i) || consume;

  opbc_ones_counter #(.WIN_LEN(WIN_LEN)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .take_i(take),
    .bit_i(smp_bit_i), .ones_o(ones), .last_o(last)
  );

  opbc_bin_classifier #(.WIN_LEN(WIN_LEN), .NUM_BINS(NUM_BINS)) cls_i (
    .ones_i(ones), .bin_o(bin)
  );

  opbc_labeler #(.NUM_BINS(NUM_BINS)) lab_i (
    .bin_i(bin), .code_o(code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      done_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_MEAS;
          src_q   <= '0;
          done_q  <= 1'b0;
        end
        ST_MEAS: if (last) state_q <= ST_EMIT;
        ST_EMIT: if (code_ready_i) begin
          resp_q[src_q*CODE_W +: CODE_W] <= code;
          if (src_q == SRC_W'(NUM_SRC - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_MEAS;
            src_q   <= src_q + SRC_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign src_sel_o   = src_q;
  assign code_src_o  = src_q;
  assign code_data_o = code;
  assign done_o      = done_q;
  assign response_o  = resp_q;

  assert_hold_while_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o && !code_ready_i) |=> (code_valid_o && $stable(code_data_o) && $stable(code_src_o)));

  assert_src_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && src_q != SRC_W'(NUM_SRC - 1)) |=> (src_sel_o == $past(src_sel_o) + SRC_W'(1)));

  assert_empty_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o && ones == '0) |-> (code_data_o == '0));

  assert_full_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o && ones == CNT_W'(WIN_LEN)) |-> (code_data_o == '1));

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!smp_ready_o && !code_valid_o));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEAS && start_i && !last) |=> (state_q == ST_MEAS && $stable(src_sel_o)));
endmodule

// File: tb/opbc_top_tb_top.sv
module opbc_top_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int K = 6;
  localparam int CW = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic start_i = 0;
  logic smp_valid_i = 0;
  logic smp_bit_i = 0;
  logic code_ready;
  logic [1:0] src_sel_o, code_src_o;
  logic smp_ready_o, code_valid_o, done_o;
  logic [CW-1:0] code_data_o;
  logic [N*CW-1:0] response_o;

  int checks = 0;
  int errors = 0;
  int cnt [N];
  int code_tab [K] = '{0, 1, 2, 5, 6, 7};
  int exp_next = 0;
  int cyc = 0;
  int wd = 0;

  always #5 clk = ~clk;

  opbc_top #(.NUM_SRC(N), .WIN_LEN(W), .NUM_BINS(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_sel_o(src_sel_o),
    .smp_valid_i(smp_valid_i), .smp_bit_i(smp_bit_i), .smp_ready_o(smp_ready_o),
    .code_valid_o(code_valid_o), .code_ready_i(code_ready), .code_data_o(code_data_o),
    .code_src_o(code_src_o), .done_o(done_o), .response_o(response_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected bin from the real-valued proportion of ones
  function automatic int exp_bin(input int c);
    real x;
    if (c == 0) return 0;
    if (c == W) return K - 1;
    x = real'(c) / real'(W);
    for (int k = 1; k <= K - 2; k++)
      if (x <= real'(k) / real'(K - 2)) return k;
    return K - 2;
  endfunction

  // Code consumer with a stall pattern; checks R4..R9
  always @(negedge clk) begin
    if (!rst_n) begin
      code_ready = 0;
    end else begin
      cyc++;
      code_ready = (cyc % 3 != 0);
      if (code_valid_o) begin
        chk(smp_ready_o == 0, "R8 no sample while code pending", smp_ready_o, 0);
        chk(code_src_o == exp_next, "R9 source order", code_src_o, exp_next);
        chk(code_data_o == code_tab[exp_bin(cnt[code_src_o])],
            "R4/R5/R6/R7 code for count", code_data_o, code_tab[exp_bin(cnt[code_src_o])]);
        if (code_ready) exp_next = (exp_next + 1) % N;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic measure(input int s, input int c, input bit poke);
    int acc = 0;
    bit r;
    bit poked = 0;
    while (acc < W) begin
      @(negedge clk);
      start_i = 0;
      if (poked && acc == 4) begin
        chk(src_sel_o == s && smp_ready_o, "R12 start ignored mid-window", src_sel_o, s);
        poked = 0;
      end
      if (poke && acc == 3) begin
        start_i = 1;
        poked = 1;
        poke = 0;
      end
      smp_valid_i = 1;
      smp_bit_i = (((acc * 5 + s) % W) < c);
      r = smp_ready_o;
      if (r) chk(src_sel_o == s, "R3 source selected while sampling", src_sel_o, s);
      @(posedge clk);
      if (r) acc++;
    end
    @(negedge clk);
    start_i = 0;
    smp_valid_i = 0;
  endtask

  initial begin
    int sets [3][N] = '{'{0, 8, 1, 2}, '{3, 4, 5, 6}, '{7, 0, 8, 4}};
    logic [N*CW-1:0] er;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(src_sel_o == 0 && !smp_ready_o && !code_valid_o && !done_o && response_o == 0,
        "R1 reset state", {src_sel_o, smp_ready_o, code_valid_o, done_o}, 0);
    for (int p = 0; p < 3; p++) begin
      for (int s = 0; s < N; s++) cnt[s] = sets[p][s];
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk(smp_ready_o && src_sel_o == 0 && !done_o, "R2 sweep starts at source 0",
          {smp_ready_o, src_sel_o, done_o}, 4'b1000);
      for (int s = 0; s < N; s++) measure(s, cnt[s], p == 1 && s == 1);
      while (!done_o) @(negedge clk);
      er = '0;
      for (int s = 0; s < N; s++) er[s*CW +: CW] = CW'(code_tab[exp_bin(cnt[s])]);
      chk(response_o == er, "R10 concatenated response", response_o, er);
      repeat (3) @(negedge clk);
      chk(done_o && !smp_ready_o && !code_valid_o, "R11 done holds while idle",
          {done_o, smp_ready_o, code_valid_o}, 3'b100);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule